// File: doc/BRIEF.md
# Four-Channel DMA Parameter Register File

This block stores the per-channel transfer parameters of a four-channel DMA engine and keeps them up to date while transfers run. Every channel owns a 16-bit address register and a 16-bit count word. The count word carries a 14-bit cycle count and a 2-bit transfer kind. A shared mode register holds the channel enables and four option bits. A status byte reports terminal count per channel and an autoload update flag. A processor programs the block one byte at a time through a slave port. An internal byte pointer chooses whether each access reaches the low byte or the high byte of a 16-bit register.

The transfer sequencer pulses `xfer_done` with a channel number each time a transfer cycle on that channel completes. In that same cycle the block shows the address that transfer used, its kind, and whether the cycle was the terminal one or a mark cycle. At the next clock edge it advances the address and count. When autoload is on, channel 3 acts as a template for channel 2. After channel 2 finishes its block, its next transfer runs from channel 3's parameters, so channel 2 can repeat the same block without processor help. Bus arbitration, the address latches and strobe generation sit outside this block.

Top module: `dma_chan_regfile`

## Requirements
- R1: `cpu_sel` = 8 (bit 3 set) reaches the mode register on a write and the status byte on a read. `cpu_sel` = 2*c selects channel c's address and 2*c+1 selects its count word. Each read or write of a channel register goes to the low byte when the byte pointer is 0 and to the high byte when it is 1, and then toggles the pointer. Reset and any mode write clear the pointer.
- R2: Count word bits [13:0] hold the cycle count and bits [15:14] hold the transfer kind (00 verify, 01 write, 10 read). `xfer_kind` shows the kind of the channel in use.
- R3: On each accepted transfer the channel's address goes up by one and its count goes down by one. `xfer_addr` shows the address in use before the increment.
- R4: `xfer_tc` goes high on the accepted transfer whose count field is 0. A count loaded with N-1 therefore gives N transfers, and only the last one is terminal.
- R5: At terminal count the channel's status bit sets. Status byte bits [3:0] are channels 0..3 and bit 4 is the update flag. A status bit stays set until a status read, which clears it, or until reset.
- R6: A status read never clears the update flag.
- R7: When mode bit 7 (autoload) is set, terminal count on channel 2 sets the update flag. The next accepted channel-2 transfer uses channel 3's address, kind and count. Channel 2 is left holding channel 3's values advanced by one step, and the flag clears unless that transfer is itself terminal. Channel 3 does not change.
- R8: Mode bits [3:0] enable channels 0..3. A transfer on a disabled channel changes no register and raises neither `xfer_tc` nor `xfer_mark`. Mode bits [7:4] appear on `opt_flags`.
- R9: Reset clears the mode register, the status bits, the update flag and all channel registers.
- R10: `xfer_mark` goes high on an accepted transfer whose count field modulo 128 is 0.
- R11: When mode bit 6 is set, terminal count clears that channel's enable bit. The exception is channel 2 while autoload is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 4 | Register select for the slave access |
| cpu_wr | input | 1 | Slave write strobe, one cycle per byte |
| cpu_rd | input | 1 | Slave read strobe, one cycle per byte |
| cpu_wdata | input | 8 | Slave write data |
| cpu_rdata | output | 8 | Slave read data, combinational from select and byte pointer |
| xfer_done | input | 1 | A transfer cycle on `xfer_ch` completes this cycle |
| xfer_ch | input | 2 | Channel of the completing transfer |
| xfer_addr | output | 16 | Address used by the transfer on `xfer_ch` |
| xfer_kind | output | 2 | Transfer kind of `xfer_ch` |
| xfer_tc | output | 1 | This accepted transfer is the terminal one |
| xfer_mark | output | 1 | This accepted transfer is a mark cycle |
| ch_enable | output | 4 | Channel enable bits |
| opt_flags | output | 4 | Option bits of the mode register |
| update_busy | output | 1 | Autoload update flag |

## Verification
The assertions assume that a processor write to a channel register never lands in the same cycle as a transfer on that channel. They also assume that `cpu_wr` and `cpu_rd` are never both high. The step and reload properties only fire when no write is present, so a write taking priority cannot trip them. The bench keeps slave accesses and transfer pulses in separate cycles, with one strobe per cycle. It applies transfers only after the channel has been fully programmed.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
   typedef enum logic [1:0] {
      KIND_VERIFY = 2'b00,
      KIND_WRITE  = 2'b01,
      KIND_READ   = 2'b10,
      KIND_RSVD   = 2'b11
   } xfer_kind_e;

   // bit positions inside the 4-bit option field (mode bits 7:4)
   localparam int OPT_AUTOLOAD_BIT = 3;
   localparam int OPT_TC_STOP_BIT  = 2;
   localparam int BYTE_W           = 8;
endpackage

// File: rtl/dma_rf_chan.sv
module dma_rf_chan #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_addr,
   input  logic              wr_cnt,
   input  logic              hi_sel,
   input  logic [7:0]        wdata,
   input  logic              step,
   input  logic              reload,
   input  logic [ADDR_W-1:0] src_addr,
   input  logic [CNT_W+1:0]  src_cnt,
   output logic [ADDR_W-1:0] addr_q,
   output logic [CNT_W+1:0]  cnt_q
);
   localparam int WORD_W = CNT_W + 2;

   logic [ADDR_W-1:0] base_addr;
   logic [WORD_W-1:0] base_cnt;

   assign base_addr = reload ? src_addr : addr_q;
   assign base_cnt  = reload ? src_cnt  : cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (wr_addr) begin
         if (hi_sel) addr_q[ADDR_W-1:8] <= wdata;
         else        addr_q[7:0]        <= wdata;
      end else if (step) begin
         addr_q <= base_addr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wr_cnt) begin
         if (hi_sel) cnt_q[WORD_W-1:8] <= wdata;
         else        cnt_q[7:0]        <= wdata;
      end else if (step) begin
         cnt_q <= {base_cnt[WORD_W-1:CNT_W], base_cnt[CNT_W-1:0] - 1'b1};
      end
   end

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      step && !reload && !wr_addr |=> addr_q == $past(addr_q) + 1'b1); // R3
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      step && !reload && !wr_cnt |=> cnt_q[CNT_W-1:0] == $past(cnt_q[CNT_W-1:0]) - 1'b1); // R3
   AST_KIND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      step && !reload && !wr_cnt |=> $stable(cnt_q[WORD_W-1:CNT_W])); // R2
   AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      step && reload && !wr_addr |=> addr_q == $past(src_addr) + 1'b1); // R7
endmodule

// File: rtl/dma_rf_ctrl.sv
module dma_rf_ctrl #(
   parameter int NUM_CH = 4,
   parameter int OPT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic              chan_acc,
   input  logic [7:0]        wdata,
   input  logic [NUM_CH-1:0] tc_stop_clr,
   output logic [NUM_CH-1:0] en_q,
   output logic [OPT_W-1:0]  opt_q,
   output logic              byte_hi
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= '0;
         opt_q <= '0;
      end else if (mode_wr) begin
         {opt_q, en_q} <= wdata;
      end else begin
         en_q <= en_q & ~tc_stop_clr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || mode_wr) byte_hi <= 1'b0;
      else if (chan_acc)     byte_hi <= ~byte_hi;
   end

   AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      chan_acc && !mode_wr |=> byte_hi != $past(byte_hi)); // R1
   AST_EN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_wr |=> (en_q & ~$past(en_q)) == '0); // R8
endmodule

// File: rtl/dma_rf_status.sv
module dma_rf_status #(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] tc_set,
   input  logic              stat_rd,
   input  logic              upd_set,
   input  logic              upd_done,
   output logic [NUM_CH-1:0] tc_q,
   output logic              upd_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tc_q  <= '0;
         upd_q <= 1'b0;
      end else begin
         tc_q <= (stat_rd ? '0 : tc_q) | tc_set;
         if (upd_set)       upd_q <= 1'b1;
         else if (upd_done) upd_q <= 1'b0;
      end
   end

   AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rd |=> (tc_q & $past(tc_q)) == $past(tc_q)); // R5
   AST_UPD_SURVIVES_READ: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd && upd_q && !upd_done |=> upd_q); // R6
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile #(
   parameter int NUM_CH    = 4,
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 14,
   parameter int OPT_W     = 4,
   parameter int MARK_LOG2 = 7,
   parameter int AUTO_DST  = 2,
   parameter int AUTO_SRC  = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(NUM_CH)+1:0]  cpu_sel,
   input  logic                       cpu_wr,
   input  logic                       cpu_rd,
   input  logic [7:0]                 cpu_wdata,
   output logic [7:0]                 cpu_rdata,
   input  logic                       xfer_done,
   input  logic [$clog2(NUM_CH)-1:0]  xfer_ch,
   output logic [ADDR_W-1:0]          xfer_addr,
   output logic [1:0]                 xfer_kind,
   output logic                       xfer_tc,
   output logic                       xfer_mark,
   output logic [NUM_CH-1:0]          ch_enable,
   output logic [OPT_W-1:0]           opt_flags,
   output logic                       update_busy
);
   import dma_rf_pkg::*;

   localparam int CH_W   = $clog2(NUM_CH);
   localparam int SEL_W  = CH_W + 2;
   localparam int WORD_W = CNT_W + 2;

   if (ADDR_W != 2*BYTE_W)            begin : g_bad_addr $error("ADDR_W must be two bytes"); end
   if (WORD_W != 2*BYTE_W)            begin : g_bad_cnt  $error("count word must be two bytes"); end
   if (NUM_CH + OPT_W != BYTE_W)      begin : g_bad_mode $error("mode must fit one byte"); end
   if (NUM_CH != (1 << CH_W))         begin : g_bad_ch   $error("NUM_CH must be a power of two"); end
   if (AUTO_DST >= NUM_CH || AUTO_SRC >= NUM_CH || AUTO_DST == AUTO_SRC)
                                      begin : g_bad_auto $error("bad autoload channels"); end
   if (MARK_LOG2 < 1 || MARK_LOG2 > CNT_W) begin : g_bad_mark $error("bad MARK_LOG2"); end

   // slave decode
   logic            acc_mode, is_cnt, mode_wr, stat_rd, chan_acc;
   logic [CH_W-1:0] chan_idx;
   assign acc_mode = cpu_sel[SEL_W-1];
   assign is_cnt   = cpu_sel[0];
   assign chan_idx = cpu_sel[CH_W:1];
   assign mode_wr  = cpu_wr & acc_mode;
   assign stat_rd  = cpu_rd & acc_mode;
   assign chan_acc = (cpu_wr | cpu_rd) & ~acc_mode;

   logic [NUM_CH-1:0] en_q, tc_q, step, tc_set, stop_clr;
   logic [OPT_W-1:0]  opt_q;
   logic              byte_hi, upd_q, upd_set, upd_done, autoload, tc_stop;
   logic [ADDR_W-1:0] addr_a [NUM_CH];
   logic [WORD_W-1:0] cnt_a  [NUM_CH];

   assign autoload = opt_q[OPT_AUTOLOAD_BIT];
   assign tc_stop  = opt_q[OPT_TC_STOP_BIT];

   // effective parameters of the transfer in progress
   logic              use_src, act, cnt_zero;
   logic [ADDR_W-1:0] eff_addr;
   logic [WORD_W-1:0] eff_cnt;
   assign use_src  = upd_q && (xfer_ch == CH_W'(AUTO_DST));
   assign eff_addr = use_src ? addr_a[AUTO_SRC] : addr_a[xfer_ch];
   assign eff_cnt  = use_src ? cnt_a[AUTO_SRC]  : cnt_a[xfer_ch];
   assign act      = xfer_done & en_q[xfer_ch];
   assign cnt_zero = (eff_cnt[CNT_W-1:0] == '0);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic sel_me, wr_a, wr_c;
      assign sel_me      = cpu_wr & ~acc_mode & (chan_idx == CH_W'(i));
      assign wr_a        = sel_me & ~is_cnt;
      assign wr_c        = sel_me &  is_cnt;
      assign step[i]     = act & (xfer_ch == CH_W'(i));
      assign tc_set[i]   = step[i] & cnt_zero;
      if (i == AUTO_DST) begin : g_dst
         assign stop_clr[i] = tc_set[i] & tc_stop & ~autoload;
      end else begin : g_plain
         assign stop_clr[i] = tc_set[i] & tc_stop;
      end
      dma_rf_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_addr (wr_a),
         .wr_cnt  (wr_c),
         .hi_sel  (byte_hi),
         .wdata   (cpu_wdata),
         .step    (step[i]),
         .reload  ((i == AUTO_DST) ? upd_q : 1'b0),
         .src_addr(addr_a[AUTO_SRC]),
         .src_cnt (cnt_a[AUTO_SRC]),
         .addr_q  (addr_a[i]),
         .cnt_q   (cnt_a[i])
      );
   end

   assign upd_set  = tc_set[AUTO_DST] & autoload;
   assign upd_done = step[AUTO_DST] & upd_q;

   dma_rf_ctrl #(.NUM_CH(NUM_CH), .OPT_W(OPT_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_wr    (mode_wr),
      .chan_acc   (chan_acc),
      .wdata      (cpu_wdata),
      .tc_stop_clr(stop_clr),
      .en_q       (en_q),
      .opt_q      (opt_q),
      .byte_hi    (byte_hi)
   );

   dma_rf_status #(.NUM_CH(NUM_CH)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .tc_set  (tc_set),
      .stat_rd (stat_rd),
      .upd_set (upd_set),
      .upd_done(upd_done),
      .tc_q    (tc_q),
      .upd_q   (upd_q)
   );

   // read mux
   logic [2*BYTE_W-1:0] rd_word;
   assign rd_word = is_cnt ? cnt_a[chan_idx] : addr_a[chan_idx];
   always_comb begin
      if (acc_mode) cpu_rdata = BYTE_W'({upd_q, tc_q});
      else          cpu_rdata = byte_hi ? rd_word[2*BYTE_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
   end

   assign xfer_addr   = eff_addr;
   assign xfer_kind   = eff_cnt[WORD_W-1:CNT_W];
   assign xfer_tc     = act & cnt_zero;
   assign xfer_mark   = act & (eff_cnt[MARK_LOG2-1:0] == '0);
   assign ch_enable   = en_q;
   assign opt_flags   = opt_q;
   assign update_busy = upd_q;

   AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done && !en_q[xfer_ch] && !cpu_wr |=> addr_a[$past(xfer_ch)] == $past(addr_a[xfer_ch])); // R8
   AST_TC_IS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_tc |-> xfer_mark); // R10
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_wr && cpu_rd)); // R1
endmodule

// File: tb/sim_dma_chan_regfile.sv
module sim_dma_chan_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cpu_sel = '0;
   logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata;
   logic        xfer_done = 1'b0;
   logic [1:0]  xfer_ch = '0;
   logic [15:0] xfer_addr;
   logic [1:0]  xfer_kind;
   logic        xfer_tc, xfer_mark, update_busy;
   logic [3:0]  ch_enable, opt_flags;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   dma_chan_regfile u0 (
      .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .xfer_done(xfer_done), .xfer_ch(xfer_ch),
      .xfer_addr(xfer_addr), .xfer_kind(xfer_kind), .xfer_tc(xfer_tc), .xfer_mark(xfer_mark),
      .ch_enable(ch_enable), .opt_flags(opt_flags), .update_busy(update_busy)
   );

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr8(logic [3:0] sel, logic [7:0] d);
      @(negedge clk); cpu_sel = sel; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk); cpu_wr = 1'b0;
   endtask

   task automatic rd8(logic [3:0] sel, output logic [7:0] d);
      @(negedge clk); cpu_sel = sel; cpu_rd = 1'b1;
      #1 d = cpu_rdata;
      @(negedge clk); cpu_rd = 1'b0;
   endtask

   task automatic rd16(logic [3:0] sel, output logic [15:0] w);
      logic [7:0] lo, hi;
      rd8(sel, lo); rd8(sel, hi);
      w = {hi, lo};
   endtask

   task automatic prog(int ch, logic [15:0] a, logic [15:0] c);
      wr8(4'(2*ch), a[7:0]);   wr8(4'(2*ch), a[15:8]);
      wr8(4'(2*ch+1), c[7:0]); wr8(4'(2*ch+1), c[15:8]);
   endtask

   task automatic xfer(int ch, string req, int ea, int etc, int emark);
      @(negedge clk); xfer_ch = 2'(ch); xfer_done = 1'b1;
      #1;
      chk({req, " addr"}, xfer_addr, ea);
      chk({req, " tc"},   xfer_tc, etc);
      chk({req, " mark"}, xfer_mark, emark);
      @(negedge clk); xfer_done = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] s; logic [15:0] w;
      chk("R9 enables", ch_enable, 0);
      chk("R9 options", opt_flags, 0);
      chk("R9 update", update_busy, 0);
      rd8(4'd8, s);  chk("R9 status", s, 0);
      rd16(4'd7, w); chk("R9 ch3 count", w, 0);
   endtask

   task automatic t_basic;
      logic [15:0] w; logic [7:0] s;
      prog(0, 16'h1234, 16'h8003);            // kind read, N=4
      rd16(4'd0, w); chk("R1 addr readback", w, 16'h1234);
      rd16(4'd1, w); chk("R2 count readback", w, 16'h8003);
      wr8(4'd8, 8'h01);
      for (int k = 0; k < 4; k++) begin
         xfer(0, "R3 R4", 16'h1234 + k, (k == 3) ? 1 : 0, (k == 3) ? 1 : 0);
      end
      chk("R2 kind", xfer_kind, 2);
      rd16(4'd0, w); chk("R3 addr after", w, 16'h1238);
      rd8(4'd8, s); chk("R5 tc set", s, 8'h01);
      rd8(4'd8, s); chk("R5 cleared by read", s, 8'h00);
   endtask

   task automatic t_disabled;
      logic [15:0] w;
      prog(1, 16'h0500, 16'h0004);
      xfer(1, "R8 disabled", 16'h0500, 0, 0);
      rd16(4'd2, w); chk("R8 addr unchanged", w, 16'h0500);
      rd16(4'd3, w); chk("R8 count unchanged", w, 16'h0004);
   endtask

   task automatic t_mark;
      logic [7:0] s;
      prog(1, 16'h2000, 16'd129);             // N=130
      wr8(4'd8, 8'h02);
      for (int k = 0; k < 130; k++) begin
         xfer(1, "R10 mark", 16'h2000 + k, (k == 129) ? 1 : 0, (((129 - k) % 128) == 0) ? 1 : 0);
      end
      rd8(4'd8, s); chk("R5 ch1 tc", s, 8'h02);
   endtask

   task automatic t_stop;
      logic [15:0] w;
      prog(0, 16'h0040, 16'h0000);
      wr8(4'd8, 8'h41);
      chk("R8 options out", opt_flags, 4'h4);
      xfer(0, "R11 tc", 16'h0040, 1, 1);
      chk("R11 enable cleared", ch_enable, 0);
      xfer(0, "R11 now disabled", 16'h0041, 0, 0);
      rd16(4'd0, w); chk("R11 addr", w, 16'h0041);
   endtask

   task automatic t_ptr;
      logic [15:0] w;
      wr8(4'd0, 8'hAA);                        // pointer now high
      wr8(4'd8, 8'h00);                        // mode write clears pointer
      wr8(4'd0, 8'h55); wr8(4'd0, 8'h66);
      rd16(4'd0, w); chk("R1 pointer reset by mode write", w, 16'h6655);
   endtask

   task automatic t_auto;
      logic [7:0] s; logic [15:0] w;
      rd8(4'd8, s);
      prog(2, 16'h0100, 16'h0001);
      prog(3, 16'h0200, 16'h4002);
      wr8(4'd8, 8'hC4);
      xfer(2, "R7 first", 16'h0100, 0, 0);
      xfer(2, "R7 tc", 16'h0101, 1, 1);
      chk("R7 update set", update_busy, 1);
      chk("R11 ch2 kept", ch_enable, 4'h4);
      rd8(4'd8, s); chk("R5 status with update", s, 8'h14);
      rd8(4'd8, s); chk("R6 update survives read", s, 8'h10);
      xfer(2, "R7 reload", 16'h0200, 0, 0);
      chk("R7 update cleared", update_busy, 0);
      rd16(4'd5, w); chk("R7 ch2 count after reload", w, 16'h4001);
      xfer(2, "R7 continue", 16'h0201, 0, 0);
      chk("R2 kind from template", xfer_kind, 1);
      xfer(2, "R7 second tc", 16'h0202, 1, 1);
      chk("R7 update again", update_busy, 1);
      rd16(4'd6, w); chk("R7 ch3 addr unchanged", w, 16'h0200);
      rd16(4'd7, w); chk("R7 ch3 count unchanged", w, 16'h4002);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_basic;
      t_disabled;
      t_mark;
      t_stop;
      t_ptr;
      t_auto;
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 8);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule